// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Word Memory

This block is a small local data store made of 32-bit words and addressed by byte. A client presents a byte address, a size select and, for stores, a data word with a write strobe. Word loads and word stores move a whole 32-bit word. Byte loads pick one byte out of a word and return it sign-extended to 32 bits. Reads are combinational from the current contents, and stores land on the rising clock edge.

A static select input chooses how the four byte offsets inside a word map onto the bits of the stored value. With little-endian ordering, the byte at offset 0 is the least significant byte. With big-endian ordering, offset 0 holds the most significant byte. A word access must sit on a multiple of four. If it does not, the block raises an error flag in that cycle and refuses to write. Word address bits beyond the configured depth are dropped, so addresses wrap around the array.

Top module: `endian_mem_port`

## Requirements
- R1: After reset is released, every word of the array reads as 0x00000000.
- R2: A word store (size_byte_i = 0, addr_i[1:0] = 00, wr_en_i = 1) writes wdata_i into the addressed word at the rising clock edge. Until that edge a load from the same address still returns the old contents.
- R3: A word access with addr_i[1:0] != 00 drives misalign_o high in the same cycle, and rdata_o is 0x00000000 while misalign_o is high.
- R4: A misaligned word store leaves the memory unchanged.
- R5: With big_endian_i = 0, a byte load (size_byte_i = 1) at offset o = addr_i[1:0] returns bits [8o+7:8o] of the stored word.
- R6: With big_endian_i = 1, a byte load at offset o returns bits [8(3-o)+7:8(3-o)] of the stored word.
- R7: A byte load never raises misalign_o, and rdata_o[31:8] all equal the selected byte's bit 7 (sign extension).
- R8: A store request with size_byte_i = 1 leaves the memory unchanged.
- R9: The word index is addr_i[IDX_W+1:2] with IDX_W = log2(DEPTH). Higher address bits are ignored, so the address wraps modulo the depth.
- R10: A word load returns the stored word unchanged, whatever the setting of big_endian_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the array |
| big_endian_i | input | 1 | 1 selects big-endian byte lanes, 0 selects little-endian |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Store data |
| wr_en_i | input | 1 | Store request |
| size_byte_i | input | 1 | 1 = byte access, 0 = word access |
| rdata_o | output | 32 | Load data, combinational |
| misalign_o | output | 1 | Misaligned word access, same cycle |

## Verification
A store and a load of the same word can fall in the same cycle. The combinational read must show the pre-store value up to the edge and the new value right after it. The bench holds one aligned address with the strobe high. It samples rdata_o before the edge against the shadow's old word and after the edge against the written word. A misaligned store also meets the error flag in one cycle. That case is provoked with each nonzero offset, and a later aligned load must show the word untouched.

// File: rtl/endian_mem_pkg.sv
package endian_mem_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned LANES    = WORD_W / BYTE_W;
   localparam int unsigned OFF_W    = $clog2(LANES);

   typedef logic [OFF_W-1:0] lane_t;

   // Physical lane of a byte offset under the chosen ordering.
   function automatic lane_t lane_of(input lane_t off, input logic big);
      return big ? lane_t'(LANES - 1 - off) : off;
   endfunction
endpackage

// File: rtl/emp_addr_decode.sv
module emp_addr_decode
   import endian_mem_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned IDX_W  = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic              size_byte_i,
   output logic [IDX_W-1:0]  idx_o,
   output lane_t             off_o,
   output logic              misalign_o,
   output logic              wr_en_o
);
   assign idx_o      = addr_i[IDX_W+OFF_W-1:OFF_W];
   assign off_o      = addr_i[OFF_W-1:0];
   assign misalign_o = !size_byte_i && (addr_i[OFF_W-1:0] != '0);
   assign wr_en_o    = wr_en_i && !size_byte_i && (addr_i[OFF_W-1:0] == '0);
endmodule

// File: rtl/emp_word_array.sv
module emp_word_array
   import endian_mem_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              wr_en_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] rd_word_o
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  row_we;

   for (genvar g = 0; g < DEPTH; g++) begin : g_row_sel
      assign row_we[g] = wr_en_i && (idx_i == IDX_W'(g));
   end

   always_ff @(posedge clk) begin
      for (int r = 0; r < DEPTH; r++) begin
         if (!rst_n)         mem[r] <= '0;
         else if (row_we[r]) mem[r] <= wdata_i;
      end
   end

   assign rd_word_o = mem[idx_i];
endmodule

// File: rtl/emp_byte_extract.sv
module emp_byte_extract
   import endian_mem_pkg::*;
(
   input  logic [WORD_W-1:0] word_i,
   input  lane_t             off_i,
   input  logic              big_endian_i,
   output logic [WORD_W-1:0] sext_o
);
   logic [BYTE_W-1:0] lanes [LANES];
   logic [BYTE_W-1:0] pick;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lanes[l] = word_i[l*BYTE_W +: BYTE_W];
   end

   assign pick   = lanes[lane_of(off_i, big_endian_i)];
   assign sext_o = {{(WORD_W-BYTE_W){pick[BYTE_W-1]}}, pick};
endmodule

// File: rtl/endian_mem_port.sv
module endian_mem_port
   import endian_mem_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   input  logic              wr_en_i,
   input  logic              size_byte_i,
   output logic [31:0]       rdata_o,
   output logic              misalign_o
);
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < IDX_W + OFF_W) begin : g_bad_addr
      $error("ADDR_W too narrow for DEPTH");
   end

   logic [IDX_W-1:0]  idx;
   lane_t             off;
   logic              wr_en;
   logic [WORD_W-1:0] rd_word;
   logic [WORD_W-1:0] byte_sext;

   emp_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
      .addr_i      (addr_i),
      .wr_en_i     (wr_en_i),
      .size_byte_i (size_byte_i),
      .idx_o       (idx),
      .off_o       (off),
      .misalign_o  (misalign_o),
      .wr_en_o     (wr_en)
   );

   emp_word_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) arr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_i     (idx),
      .wr_en_i   (wr_en),
      .wdata_i   (wdata_i),
      .rd_word_o (rd_word)
   );

   emp_byte_extract ext_i (
      .word_i       (rd_word),
      .off_i        (off),
      .big_endian_i (big_endian_i),
      .sext_o       (byte_sext)
   );

   always_comb begin
      if (misalign_o)       rdata_o = '0;
      else if (size_byte_i) rdata_o = byte_sext;
      else                  rdata_o = rd_word;
   end
endmodule

// File: rtl/endian_mem_port_chk.sv
module endian_mem_port_chk #(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic [31:0]       wdata_i,
   input logic              size_byte_i,
   input logic [31:0]       rdata_o,
   input logic              misalign_o,
   input logic              wr_en,
   input logic [31:0]       rd_word
);
   // R4
   misalign_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> !wr_en);
   // R8
   byte_store_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      size_byte_i |-> !wr_en);
   // R3
   misalign_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> rdata_o == 32'h0);
   // R7
   byte_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      size_byte_i |-> (rdata_o[31:7] == '0 || rdata_o[31:7] == '1));
   // R7
   byte_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      size_byte_i |-> !misalign_o);
   // R2
   store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en ##1 $stable(addr_i) |-> rd_word == $past(wdata_i));
   // R10
   word_load_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!size_byte_i && !misalign_o) |-> rdata_o == rd_word);
endmodule

bind endian_mem_port endian_mem_port_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_i      (addr_i),
   .wdata_i     (wdata_i),
   .size_byte_i (size_byte_i),
   .rdata_o     (rdata_o),
   .misalign_o  (misalign_o),
   .wr_en       (wr_en),
   .rd_word     (rd_word)
);

// File: tb/endian_mem_port_tb.sv
module endian_mem_port_tb_top;
   localparam int DEPTH  = 16;
   localparam int ADDR_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              big_endian_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [31:0]       wdata_i = '0;
   logic              wr_en_i = 1'b0;
   logic              size_byte_i = 1'b0;
   logic [31:0]       rdata_o;
   logic              misalign_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] shadow [DEPTH];

   always #4 clk = ~clk;

   endian_mem_port #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .wr_en_i(wr_en_i), .size_byte_i(size_byte_i),
      .rdata_o(rdata_o), .misalign_o(misalign_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] patt(input int i);
      return 32'h80FF_017F ^ (32'(i) * 32'h1122_3347);
   endfunction

   function automatic logic [31:0] exp_byte(input logic [31:0] w, input int off, input logic be);
      int ln;
      logic [7:0] b;
      ln = be ? 3 - off : off;
      b = w[8*ln +: 8];
      return {{24{b[7]}}, b};
   endfunction

   task automatic load(input logic [7:0] a, input logic sb, input logic be);
      @(negedge clk);
      addr_i = a; size_byte_i = sb; big_endian_i = be; wr_en_i = 1'b0;
      #1;
   endtask

   task automatic store(input logic [7:0] a, input logic [31:0] d, input logic sb);
      @(negedge clk);
      addr_i = a; wdata_i = d; size_byte_i = sb; wr_en_i = 1'b1;
      @(posedge clk);
      #1;
      wr_en_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: cleared array
      for (int i = 0; i < DEPTH; i++) begin
         load(8'(4*i), 1'b0, 1'b0);
         check("R1", rdata_o, 32'h0);
      end

      // R2: store, old value visible until the edge, new one after
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         addr_i = 8'(4*i); wdata_i = patt(i); size_byte_i = 1'b0; wr_en_i = 1'b1;
         #1;
         check("R2 pre-edge", rdata_o, 32'h0);
         @(posedge clk);
         #1;
         check("R2 post-edge", rdata_o, patt(i));
         wr_en_i = 1'b0;
         shadow[i] = patt(i);
      end

      // R10: word loads under both orderings
      for (int be = 0; be < 2; be++)
         for (int i = 0; i < DEPTH; i++) begin
            load(8'(4*i), 1'b0, 1'(be));
            check("R10", rdata_o, shadow[i]);
            check("R7 no flag word aligned", 32'(misalign_o), 32'h0);
         end

      // R5 / R6 / R7: every byte under both orderings
      for (int be = 0; be < 2; be++)
         for (int i = 0; i < DEPTH; i++)
            for (int o = 0; o < 4; o++) begin
               load(8'(4*i + o), 1'b1, 1'(be));
               check(be ? "R6 R7" : "R5 R7", rdata_o, exp_byte(shadow[i], o, 1'(be)));
               check("R7 flag", 32'(misalign_o), 32'h0);
            end

      // R3: misaligned word loads
      for (int o = 1; o < 4; o++) begin
         load(8'(4*2 + o), 1'b0, 1'b0);
         check("R3 flag", 32'(misalign_o), 32'h1);
         check("R3 data", rdata_o, 32'h0);
      end

      // R4: misaligned stores leave word untouched
      for (int o = 1; o < 4; o++) begin
         @(negedge clk);
         addr_i = 8'(4*3 + o); wdata_i = 32'hDEAD_BEEF; size_byte_i = 1'b0; wr_en_i = 1'b1;
         #1;
         check("R3 flag on store", 32'(misalign_o), 32'h1);
         @(posedge clk);
         #1;
         wr_en_i = 1'b0;
         load(8'(4*3), 1'b0, 1'b0);
         check("R4", rdata_o, shadow[3]);
      end

      // R8: byte-size store request ignored
      for (int o = 0; o < 4; o++) begin
         store(8'(4*7 + o), 32'h5A5A_5A5A, 1'b1);
         load(8'(4*7), 1'b0, 1'b0);
         check("R8", rdata_o, shadow[7]);
      end

      // R9: upper address bits ignored
      store(8'h94, 32'h0BAD_F00D, 1'b0);
      shadow[5] = 32'h0BAD_F00D;
      load(8'h14, 1'b0, 1'b0);
      check("R9 alias low", rdata_o, shadow[5]);
      load(8'hD4, 1'b0, 1'b1);
      check("R9 alias high", rdata_o, shadow[5]);
      load(8'h57, 1'b1, 1'b1);
      check("R9 byte alias", rdata_o, exp_byte(shadow[5], 3, 1'b1));

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule